// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block is a registered execution unit for a processor datapath. It takes one operand, treats it as 8, 16 or 32 bits wide, and moves its bits left or right by a count. The unit covers logical and arithmetic shifts, plain rotates, and rotates that pass through the carry flag. Every operation reports the last bit that crossed an end of the operand in the carry output. The carry input acts as a ninth, seventeenth or thirty-third operand bit for the through-carry rotates.

A caller presents the operand, width code, operation code, count and incoming carry, and pulses `start` for one cycle. The count port carries either an immediate or a register value; the unit does not distinguish them. On the next clock the result and carry are registered and `valid` goes high for that one cycle. Between operations the outputs hold their last value.

Top module: `shift_rotate_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result`, `carry_out` and `valid` are cleared to zero at that edge.
- R2: A `start` seen high at a rising edge loads `result` and `carry_out` at that edge and raises `valid` for exactly that following cycle. When `start` is low, `valid` is low and `result` and `carry_out` keep their values.
- R3: `width_sel` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 selects 32 bits. Operand bits above the selected width are ignored, and result bits above it are zero.
- R4: Only bits [4:0] of `count` are used, so a count of 33 acts as a count of 1.
- R5: `op` 0 and `op` 1 are both a left shift with zero fill. The carry gets the last bit shifted out past the top bit.
- R6: `op` 2 is a logical right shift with zero fill. The carry gets the last bit shifted out past bit 0.
- R7: `op` 3 is an arithmetic right shift that fills with copies of the original top bit. The carry gets the last bit shifted out past bit 0, so a count of width or more gives a carry equal to the sign.
- R8: `op` 4 rotates left and `op` 5 rotates right; no bits are lost, and the count is taken modulo the width. After a left rotate the carry equals result bit 0. After a right rotate it equals the top result bit.
- R9: `op` 6 rotates {carry, operand} left and `op` 7 rotates {operand, carry} right, over width+1 bits. The masked count is taken modulo width+1. The bit left in the carry position becomes `carry_out`.
- R10: When the effective count is zero (the masked count for `op` 0 to 5, the reduced count for `op` 6 and 7), the result equals the width-masked operand and `carry_out` equals `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to execute |
| width_sel | input | 2 | Operand width code |
| op | input | 3 | Operation code |
| operand | input | DATA_W (32) | Value to shift or rotate |
| count | input | CNT_W (8) | Shift or rotate count |
| carry_in | input | 1 | Incoming carry flag |
| result | output | DATA_W (32) | Registered result |
| carry_out | output | 1 | Registered carry flag |
| valid | output | 1 | High for the one cycle after `start` |

## Verification
A fault inside the unit shows at the ports in the cycle after the `start` that used it. A wrong lane, a wrong count reduction or a wrong fill shows as a `result` or `carry_out` mismatch. A broken strobe register shows as `valid` high or low in the wrong cycle. Held outputs carry a load error forward until the next `start`, so a corrupted hold appears in any idle cycle. Boundary counts (zero, exactly the width, width+1 for the through-carry rotates, above 31) and narrow widths with junk in the upper operand bits are where a mistake surfaces first.

// File: rtl/srot_pkg.sv
// Shared types and constants for the shift and rotate unit.
// Assumes the datapath is 32 bits with lanes of 8, 16 and 32 bits.
package srot_pkg;

    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SAL = 3'd1,
        OP_SHR = 3'd2,
        OP_SAR = 3'd3,
        OP_ROL = 3'd4,
        OP_ROR = 3'd5,
        OP_RCL = 3'd6,
        OP_RCR = 3'd7
    } srot_op_e;

    localparam int LANES   = 3;
    localparam int MASK_W  = 5;
    localparam int BASE_W  = 8;

endpackage

// File: rtl/srot_lane.sv
// One fixed-width datapath lane: computes every shift and rotate for a
// W-bit operand and picks the one that op asks for.
// Assumes n is already masked to 5 bits; the lane reduces it further for
// rotates. An effective count of zero passes the operand and carry through.
module srot_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0]             x,
    input  logic                     cin,
    input  logic [srot_pkg::MASK_W-1:0] n,
    input  srot_pkg::srot_op_e       op,
    output logic [W-1:0]             res,
    output logic                     cout
);
    import srot_pkg::*;

    localparam int RCW = W + 1;
    localparam int EXT = 32;

    logic [MASK_W-1:0]  rot_k;
    logic [5:0]         rc_m;
    logic [W+EXT-1:0]   shl_t;
    logic [W+EXT:0]     shr_t;
    logic signed [W+EXT:0] sar_t;
    logic [2*W-1:0]     rol_t;
    logic [2*W-1:0]     ror_t;
    logic [2*RCW-1:0]   rcl_t;
    logic [2*RCW-1:0]   rcr_t;
    logic [W-1:0]       rol_r;
    logic [W-1:0]       ror_r;
    logic [RCW-1:0]     rcl_r;
    logic [RCW-1:0]     rcr_r;

    // Rotate count modulo W (W is a power of two)
    assign rot_k = n & MASK_W'(W - 1);
    // Through-carry rotate count modulo W+1
    assign rc_m  = 6'(32'(n) % RCW);

    // Shifts: wide intermediate so the last bit out lands at a fixed index
    assign shl_t = {{EXT{1'b0}}, x} << n;
    assign shr_t = {{EXT{1'b0}}, x, 1'b0} >> n;
    assign sar_t = $signed({{EXT{x[W-1]}}, x, 1'b0}) >>> n;

    // Plain rotates on a doubled copy of the operand
    assign rol_t = {x, x} << rot_k;
    assign ror_t = {x, x} >> rot_k;
    assign rol_r = rol_t[2*W-1:W];
    assign ror_r = ror_t[W-1:0];

    // Through-carry rotates on a doubled copy of the W+1-bit value
    assign rcl_t = {cin, x, cin, x} << rc_m;
    assign rcr_t = {x, cin, x, cin} >> rc_m;
    assign rcl_r = rcl_t[2*RCW-1:RCW];
    assign rcr_r = rcr_t[RCW-1:0];

    // Pick the operation result, or pass through on an effective count of zero
    always_comb begin
        res  = x;
        cout = cin;
        if (op == OP_RCL || op == OP_RCR) begin
            if (rc_m != 6'd0) begin
                if (op == OP_RCL) begin
                    res  = rcl_r[W-1:0];
                    cout = rcl_r[W];
                end else begin
                    res  = rcr_r[W:1];
                    cout = rcr_r[0];
                end
            end
        end else if (n != '0) begin
            unique case (op)
                OP_SHL, OP_SAL: begin
                    res  = shl_t[W-1:0];
                    cout = shl_t[W];
                end
                OP_SHR: begin
                    res  = shr_t[W:1];
                    cout = shr_t[0];
                end
                OP_SAR: begin
                    res  = sar_t[W:1];
                    cout = sar_t[0];
                end
                OP_ROL: begin
                    res  = rol_r;
                    cout = rol_r[0];
                end
                OP_ROR: begin
                    res  = ror_r;
                    cout = ror_r[W-1];
                end
                default: begin
                    res  = x;
                    cout = cin;
                end
            endcase
        end
    end

endmodule

// File: rtl/srot_sel.sv
// Width selector: picks the lane result named by the width code and
// returns it zero-extended to the full datapath width.
// Assumes lane g holds an (8 << g)-bit result already zero-extended.
module srot_sel #(
    parameter int DATA_W = 32,
    parameter int LANES  = 3
) (
    input  logic [LANES*DATA_W-1:0] lane_res,
    input  logic [LANES-1:0]        lane_cy,
    input  logic [1:0]              width_sel,
    output logic [DATA_W-1:0]       res,
    output logic                    cy
);
    // Codes 2 and 3 both map to the widest lane
    always_comb begin
        unique case (width_sel)
            2'd0: begin
                res = lane_res[0 +: DATA_W];
                cy  = lane_cy[0];
            end
            2'd1: begin
                res = lane_res[DATA_W +: DATA_W];
                cy  = lane_cy[1];
            end
            default: begin
                res = lane_res[(LANES-1)*DATA_W +: DATA_W];
                cy  = lane_cy[LANES-1];
            end
        endcase
    end

endmodule

// File: rtl/srot_outreg.sv
// Output stage: captures result and carry on a start pulse, holds them
// otherwise, and raises valid for the one following cycle.
// Assumes a synchronous active-low reset that clears all outputs.
module srot_outreg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] res_d,
    input  logic              cy_d,
    output logic [DATA_W-1:0] res_q,
    output logic              cy_q,
    output logic              vld_q
);
    // Capture on load, clear on reset, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            cy_q  <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= load;
            if (load) begin
                res_q <= res_d;
                cy_q  <= cy_d;
            end
        end
    end

endmodule

// File: rtl/shift_rotate_unit.sv
// Registered shift and rotate unit with carry.
// Runs one lane per operand width in parallel, selects by width code,
// and registers the chosen result. Assumes DATA_W is 32 and CNT_W >= 5.
module shift_rotate_unit #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        width_sel,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  count,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              valid
);
    import srot_pkg::*;

    logic [MASK_W-1:0]       cnt_m;
    srot_op_e                op_e;
    logic [LANES*DATA_W-1:0] lane_res;
    logic [LANES-1:0]        lane_cy;
    logic [DATA_W-1:0]       sel_res;
    logic                    sel_cy;

    // Only the low count bits take part
    assign cnt_m = count[MASK_W-1:0];
    assign op_e  = srot_op_e'(op);

    // One lane per supported width: 8, 16, 32
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = BASE_W << g;
        logic [LW-1:0] l_res;
        logic          l_cy;

        srot_lane #(.W(LW)) u_lane (
            .x    (operand[LW-1:0]),
            .cin  (carry_in),
            .n    (cnt_m),
            .op   (op_e),
            .res  (l_res),
            .cout (l_cy)
        );

        assign lane_res[g*DATA_W +: DATA_W] = DATA_W'(l_res);
        assign lane_cy[g] = l_cy;
    end

    srot_sel #(.DATA_W(DATA_W), .LANES(LANES)) u_sel (
        .lane_res  (lane_res),
        .lane_cy   (lane_cy),
        .width_sel (width_sel),
        .res       (sel_res),
        .cy        (sel_cy)
    );

    srot_outreg #(.DATA_W(DATA_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .res_d (sel_res),
        .cy_d  (sel_cy),
        .res_q (result),
        .cy_q  (carry_out),
        .vld_q (valid)
    );

endmodule

// File: rtl/srot_chk.sv
// Assertion checker for the shift and rotate unit, bound to the top.
// Assumes the default 32-bit datapath and the operation codes of the brief.
module srot_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        width_sel,
    input logic [2:0]        op,
    input logic [DATA_W-1:0] operand,
    input logic [CNT_W-1:0]  count,
    input logic              carry_in,
    input logic [DATA_W-1:0] result,
    input logic              carry_out,
    input logic              valid
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (valid == 1'b0 && result == '0 && carry_out == 1'b0));

    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);

    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(result) && $stable(carry_out)));

    p_narrow_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && width_sel == 2'd0) |=> (result[DATA_W-1:8] == '0));

    p_shl_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op <= 3'd1 && width_sel == 2'd2 && count[4:0] == 5'd1)
        |=> (result == {$past(operand[DATA_W-2:0]), 1'b0}
             && carry_out == $past(operand[DATA_W-1])));

    p_ror_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'd5 && width_sel == 2'd2 && count[4:0] != 5'd0)
        |=> (carry_out == result[DATA_W-1]));

    p_zero_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op <= 3'd5 && width_sel == 2'd2 && count[4:0] == 5'd0)
        |=> (result == $past(operand) && carry_out == $past(carry_in)));

endmodule

bind shift_rotate_unit srot_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .width_sel (width_sel),
    .op        (op),
    .operand   (operand),
    .count     (count),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out),
    .valid     (valid)
);

// File: tb/tb_shift_rotate_unit.sv
// Bench: behavioural bit-at-a-time reference model compared every clock,
// plus directed vectors with literal expected values.
module tb_shift_rotate_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  width_sel = 2'd0;
    logic [2:0]  op = 3'd0;
    logic [31:0] operand = '0;
    logic [7:0]  count = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        carry_out;
    logic        valid;

    int total = 0;
    int bad = 0;
    bit checking = 1'b0;
    bit done = 1'b0;

    logic [31:0] m_res = '0;
    logic        m_cy = 1'b0;
    logic        m_vld = 1'b0;
    string       m_tag = "R1";

    always #4 clk = ~clk;

    shift_rotate_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .width_sel(width_sel),
        .op(op), .operand(operand), .count(count), .carry_in(carry_in),
        .result(result), .carry_out(carry_out), .valid(valid)
    );

    function automatic int wbits(input logic [1:0] ws);
        return (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
    endfunction

    function automatic string op_tag(input logic [2:0] o);
        if (o <= 3'd1) return "R5";
        if (o == 3'd2) return "R6";
        if (o == 3'd3) return "R7";
        if (o <= 3'd5) return "R8";
        return "R9";
    endfunction

    // Reference: apply the operation one bit step at a time
    function automatic logic [32:0] ref_op(input logic [2:0] o, input int w,
            input logic [31:0] xin, input logic [7:0] cnt, input logic cin);
        logic [31:0] mask;
        logic [31:0] x;
        logic c;
        logic t;
        logic s;
        int n;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        x = xin & mask;
        c = cin;
        n = int'(cnt) % 32;
        if (o >= 3'd6) n = n % (w + 1);
        s = x[w-1];
        for (int i = 0; i < n; i++) begin
            case (o)
                3'd0, 3'd1: begin c = x[w-1]; x = (x << 1) & mask; end
                3'd2: begin c = x[0]; x = x >> 1; end
                3'd3: begin c = x[0]; x = (x >> 1) | (32'(s) << (w-1)); end
                3'd4: begin c = x[w-1]; x = ((x << 1) | 32'(c)) & mask; end
                3'd5: begin c = x[0]; x = (x >> 1) | (32'(c) << (w-1)); end
                3'd6: begin t = x[w-1]; x = ((x << 1) | 32'(c)) & mask; c = t; end
                default: begin t = x[0]; x = (x >> 1) | (32'(c) << (w-1)); c = t; end
            endcase
        end
        return {c, x};
    endfunction

    // Cycle model of the registered outputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_res <= '0; m_cy <= 1'b0; m_vld <= 1'b0; m_tag <= "R1";
        end else begin
            m_vld <= start;
            if (start) begin
                {m_cy, m_res} <= ref_op(op, wbits(width_sel), operand, count, carry_in);
                m_tag <= op_tag(op);
            end
        end
    end

    // Compare outputs against the model every cycle
    always @(negedge clk) begin
        if (checking) begin
            total++;
            if (valid !== m_vld) begin
                bad++;
                $display("FAIL R2 valid: got %0b expected %0b", valid, m_vld);
            end
            total++;
            if (result !== m_res || carry_out !== m_cy) begin
                bad++;
                $display("FAIL %s model: got %h/%0b expected %h/%0b",
                         m_tag, result, carry_out, m_res, m_cy);
            end
        end
    end

    task automatic check_lit(input string tag, input logic [31:0] er, input logic ec);
        total++;
        if (result !== er || carry_out !== ec || valid !== 1'b1) begin
            bad++;
            $display("FAIL %s vector: got %h/%0b/v%0b expected %h/%0b/v1",
                     tag, result, carry_out, valid, er, ec);
        end
    endtask

    // Drive one operation, then check the registered output one clock later
    task automatic vec(input string tag, input logic [1:0] ws, input logic [2:0] o,
            input logic [31:0] x, input logic [7:0] n, input logic ci,
            input logic [31:0] er, input logic ec);
        @(negedge clk);
        width_sel = ws; op = o; operand = x; count = n; carry_in = ci; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_lit(tag, er, ec);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset
        total++;
        if (result !== '0 || carry_out !== 1'b0 || valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: got %h/%0b/v%0b expected 0/0/v0", result, carry_out, valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checking = 1'b1;

        // R5 R6 R7: 8-bit shift vectors
        vec("R5", 2'd0, 3'd0, 32'h15, 8'd1, 1'b0, 32'h2A, 1'b0);
        vec("R6", 2'd0, 3'd2, 32'h2A, 8'd3, 1'b0, 32'h05, 1'b0);
        vec("R5", 2'd0, 3'd1, 32'h05, 8'd5, 1'b0, 32'hA0, 1'b0);
        vec("R7", 2'd0, 3'd3, 32'hA0, 8'd2, 1'b0, 32'hE8, 1'b0);
        vec("R7", 2'd2, 3'd3, 32'h8000_0000, 8'd31, 1'b0, 32'hFFFF_FFFF, 1'b0);
        // R8 R9: 16-bit rotate vectors
        vec("R8", 2'd1, 3'd4, 32'h1234, 8'd1, 1'b0, 32'h2468, 1'b0);
        vec("R8", 2'd1, 3'd5, 32'h1234, 8'd4, 1'b0, 32'h4123, 1'b0);
        vec("R9", 2'd1, 3'd6, 32'h1234, 8'd4, 1'b0, 32'h2340, 1'b1);
        // R8 R9: 8-bit rotate vectors
        vec("R8", 2'd0, 3'd5, 32'h43, 8'd2, 1'b0, 32'hD0, 1'b1);
        vec("R8", 2'd0, 3'd4, 32'hD0, 8'd4, 1'b1, 32'h0D, 1'b1);
        vec("R9", 2'd0, 3'd7, 32'h0D, 8'd3, 1'b1, 32'h61, 1'b1);
        vec("R9", 2'd0, 3'd6, 32'h61, 8'd4, 1'b1, 32'h1B, 1'b0);
        vec("R9", 2'd3, 3'd7, 32'h1, 8'd1, 1'b0, 32'h0, 1'b1);
        vec("R8", 2'd0, 3'd4, 32'h81, 8'd8, 1'b0, 32'h81, 1'b1);
        // R4: count 33 acts as 1
        vec("R4", 2'd0, 3'd0, 32'h15, 8'd33, 1'b0, 32'h2A, 1'b0);
        // R3: upper operand bits ignored, upper result bits zero
        vec("R3", 2'd0, 3'd5, 32'hFFFF_FF81, 8'd1, 1'b0, 32'hC0, 1'b1);
        // R10: zero count passes operand and carry through
        vec("R10", 2'd1, 3'd2, 32'h0000_BEEF, 8'd0, 1'b1, 32'hBEEF, 1'b1);
        vec("R10", 2'd0, 3'd6, 32'h5A, 8'd9, 1'b0, 32'h5A, 1'b0);
        // R2: outputs hold while idle
        repeat (3) @(negedge clk);
        total++;
        if (result !== 32'h5A || valid !== 1'b0) begin
            bad++;
            $display("FAIL R2 hold: got %h/v%0b expected 5a/v0", result, valid);
        end

        // Mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            width_sel = 2'($urandom);
            op = 3'($urandom);
            operand = $urandom;
            count = 8'($urandom);
            carry_in = 1'($urandom);
            start = (($urandom % 4) != 0);
            @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);

        // R1: reset after activity clears outputs
        vec("R5", 2'd2, 3'd0, 32'hFFFF_FFFF, 8'd4, 1'b0, 32'hFFFF_FFF0, 1'b1);
        checking = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        total++;
        if (result !== '0 || carry_out !== 1'b0 || valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: got %h/%0b/v%0b expected 0/0/v0", result, carry_out, valid);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule